// File: doc/BRIEF.md
# Instruction-Driven Serial Register Interface

This block is a serial slave port that lets a host read and write an internal byte-addressed register file. Each transaction starts with one instruction byte, shifted in by the host, that names the direction, the number of data bytes (one to four) and the first byte address. The data bytes follow in the same transaction. After the last data byte the port waits for the next instruction byte.

The port works in two wiring modes. In three-wire mode the host sends on a dedicated input pin and reads from a dedicated output pin. In two-wire mode a single bidirectional pin carries both directions; its driver is split into data, enable and input signals for the pad ring. A control byte held at address 0 of the register file selects whether consecutive data bytes go to rising or falling addresses and whether each data byte travels least or most significant bit first. Both settings are taken when an instruction byte completes and hold for the rest of that transaction.

The serial clock, chip select and data pins are sampled by a faster system clock. An active-low chip select freezes a transaction in place, and a separate asynchronous input abandons the transaction while leaving every stored byte, the control byte included, untouched.

Top module: `srp_top`

## Requirements
- R1: After system reset both output enables are low and every register byte, including the control byte at address 0, reads as 0x00.
- R2: The instruction byte is always shifted most significant bit first; bit 7 = 1 selects a read and 0 a write, bits 6:5 hold the data byte count minus one, bits 4:0 hold the first byte address.
- R3: In a write, each completed data byte is stored at the current address; after the last byte the next eight serial clocks form a new instruction byte.
- R4: In a read, the first data bit appears after the serial clock falling edge that follows the eighth rising edge of the instruction, each later bit after the next falling edge; the output bit changes only after a falling edge; input bits are taken on rising edges.
- R5: Control bit 0 = 1 makes each following data byte use the address plus one, 0 the address minus one; addresses wrap modulo 32.
- R6: Control bit 1 = 1 sends and receives data bytes least significant bit first, 0 most significant bit first; both control bits are captured when the instruction byte completes.
- R7: With the two-wire select low, input bits come from the data-in pin and read bits are driven on the data-out pin with its enable high; the bidirectional pin enable stays low.
- R8: With the two-wire select high, input bits come from the bidirectional pin input and read bits are driven on its output with its enable high; the data-out enable stays low; the two enables are never high together.
- R9: While chip select is high both output enables are low, no byte is stored and serial clock edges are ignored; when it falls again the transaction continues from the same bit.
- R10: Pulsing the I/O reset low abandons the transaction: a partly shifted byte is not stored, earlier stored bytes and the control byte keep their values, and the next eight serial clocks form a new instruction byte.
- R11: Outside the data phase of a read both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| io_rst_n | input | 1 | Asynchronous active-low reset of the transaction sequencer only |
| two_wire | input | 1 | 1 selects the bidirectional single-pin mode, 0 the separate-pin mode |
| cs_n | input | 1 | Active-low chip select; high pauses the transaction |
| sclk | input | 1 | Serial clock from the host, idles high |
| sdi | input | 1 | Serial data in (separate-pin mode) |
| sdo | output | 1 | Serial data out (separate-pin mode) |
| sdo_oe | output | 1 | Drive enable for sdo; low means high-impedance |
| sdio_i | input | 1 | Input side of the bidirectional data pin |
| sdio_o | output | 1 | Output side of the bidirectional data pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional data pin |

## Verification
The hardest states to reach are a transaction frozen by chip select part way through a byte, with serial clock edges arriving during the freeze, and an I/O reset landing between two bit times of a write whose earlier bytes are already stored. The bench reaches both with directed transactions that stop at a chosen bit index, toggle the serial clock with random data while deselected, then resume or pulse the I/O reset, and follows each with read-backs. A seeded random mix of reads and writes, wiring modes and control-byte values then covers the address-stepping and bit-order combinations, including wrap across address 0.

// File: rtl/srp_pkg.sv
package srp_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2;
  localparam int AFLD_W = 5;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic              rd;
    logic [CNT_W-1:0]  cnt_m1;
    logic [AFLD_W-1:0] addr;
  } instr_t;

  function automatic logic pick_bit(input logic [BYTE_W-1:0] b,
                                    input logic [2:0] idx,
                                    input logic lsb_first);
    return lsb_first ? b[idx] : b[3'(BYTE_W-1) - idx];
  endfunction

endpackage

// File: rtl/srp_rst_sync.sv
module srp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign rst_n_s = stg_q[STAGES-1];
endmodule

// File: rtl/srp_in_sync.sv
module srp_in_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (s == 0) begin : g_first
      always_comb d = din;
    end else begin : g_next
      always_comb d = g_stage[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end
  end

  assign dout = g_stage[STAGES-1].q;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile import srp_pkg::*; #(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ctrl_up,
  output logic              ctrl_lsb
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wr_data;
    end
  end

  assign rd_data  = mem_q[addr];
  assign ctrl_up  = mem_q[CTRL_ADDR][0];
  assign ctrl_lsb = mem_q[CTRL_ADDR][1];
endmodule

// File: rtl/srp_seq.sv
module srp_seq import srp_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic              ctrl_up,
  input  logic              ctrl_lsb,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_phase,
  output logic              out_bit
);
  localparam int BIT_W = $clog2(BYTE_W);

  phase_e            phase_q, phase_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              up_q, up_d;
  logic              lsb_q, lsb_d;
  logic              out_q, out_d;

  logic [BYTE_W-1:0] msb_shift, lsb_shift, rx_byte;
  instr_t            ins;
  logic              bit_last;
  logic              step_en;

  always_comb begin
    msb_shift = {sh_q[BYTE_W-2:0], din};
    lsb_shift = {din, sh_q[BYTE_W-1:1]};
    rx_byte   = lsb_q ? lsb_shift : msb_shift;
    ins       = instr_t'(msb_shift);
    bit_last  = (bit_q == BIT_W'(BYTE_W-1));

    phase_d = phase_q;
    bit_d   = bit_q;
    left_d  = left_q;
    addr_d  = addr_q;
    sh_d    = sh_q;
    up_d    = up_q;
    lsb_d   = lsb_q;
    out_d   = out_q;
    wr_en   = 1'b0;
    step_en = 1'b0;

    if (active && rise) begin
      bit_d = bit_q + 1'b1;
      unique case (phase_q)
        PH_INSTR: begin
          sh_d = msb_shift;
          if (bit_last) begin
            phase_d = ins.rd ? PH_RDATA : PH_WDATA;
            left_d  = ins.cnt_m1;
            addr_d  = ins.addr[ADDR_W-1:0];
            up_d    = ctrl_up;
            lsb_d   = ctrl_lsb;
          end
        end
        PH_WDATA: begin
          sh_d = rx_byte;
          if (bit_last) begin
            wr_en   = 1'b1;
            step_en = 1'b1;
          end
        end
        PH_RDATA: begin
          if (bit_last) step_en = 1'b1;
        end
        default: phase_d = PH_INSTR;
      endcase

      if (step_en) begin
        if (left_q == '0) begin
          phase_d = PH_INSTR;
        end else begin
          left_d = left_q - 1'b1;
          addr_d = up_q ? addr_q + 1'b1 : addr_q - 1'b1;
        end
      end
    end

    if (active && fall && (phase_q == PH_RDATA)) begin
      out_d = pick_bit(rd_data, bit_q, lsb_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      bit_q   <= '0;
      left_q  <= '0;
      addr_q  <= '0;
      sh_q    <= '0;
      up_q    <= 1'b0;
      lsb_q   <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      addr_q  <= addr_d;
      sh_q    <= sh_d;
      up_q    <= up_d;
      lsb_q   <= lsb_d;
      out_q   <= out_d;
    end
  end

  assign addr     = addr_q;
  assign wr_data  = rx_byte;
  assign rd_phase = (phase_q == PH_RDATA);
  assign out_bit  = out_q;
endmodule

// File: rtl/srp_top.sv
module srp_top import srp_pkg::*; #(
  parameter int ADDR_W      = 5,
  parameter int CTRL_ADDR   = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic io_rst_n,
  input  logic two_wire,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe
);
  localparam int PIN_W = 4;

  logic              sys_rst_n, seq_rst_n;
  logic [PIN_W-1:0]  pins_s;
  logic              sclk_s, cs_n_s, sdi_s, sdio_s;
  logic              sclk_prev_q;
  logic              sclk_rise, sclk_fall, cs_act, din;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic              ctrl_up, ctrl_lsb, rd_phase, out_bit;

  srp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk(clk), .arst_n(rst_n), .rst_n_s(sys_rst_n)
  );

  srp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_seq (
    .clk(clk), .arst_n(rst_n & io_rst_n), .rst_n_s(seq_rst_n)
  );

  srp_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_pins (
    .clk(clk), .rst_n(sys_rst_n),
    .din({sdio_i, sdi, cs_n, sclk}), .dout(pins_s)
  );

  assign {sdio_s, sdi_s, cs_n_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) sclk_prev_q <= 1'b1;
    else            sclk_prev_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign cs_act    = ~cs_n_s;
  assign din       = two_wire ? sdio_s : sdi_s;

  srp_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(seq_rst_n), .active(cs_act),
    .rise(sclk_rise), .fall(sclk_fall), .din(din),
    .ctrl_up(ctrl_up), .ctrl_lsb(ctrl_lsb), .rd_data(rd_data),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_phase(rd_phase), .out_bit(out_bit)
  );

  srp_regfile #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_n(sys_rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data),
    .ctrl_up(ctrl_up), .ctrl_lsb(ctrl_lsb)
  );

  assign sdo     = out_bit;
  assign sdio_o  = out_bit;
  assign sdo_oe  = rd_phase & cs_act & ~two_wire;
  assign sdio_oe = rd_phase & cs_act & two_wire;
endmodule

// File: rtl/srp_chk.sv
module srp_chk (
  input logic clk,
  input logic rst_n,
  input logic io_rst_n,
  input logic two_wire,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic sdio_o,
  input logic sdio_oe,
  input logic sclk_fall,
  input logic wr_en
);
  // R8: never both pins driven
  assert_oe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdo_oe, sdio_oe}));

  // R7: separate-pin mode leaves the shared pin undriven
  assert_sep_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !two_wire |-> !sdio_oe);

  // R8: shared-pin mode leaves the data-out pin undriven
  assert_shared_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    two_wire |-> !sdo_oe);

  // R9: deselected for several cycles means no drive and no store
  assert_pause_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> (!sdo_oe && !sdio_oe && !wr_en));

  // R10: I/O reset held low keeps the port idle
  assert_iorst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rst_n |-> (!sdo_oe && !sdio_oe && !wr_en));

  // R4: a driven read bit only moves after a serial clock falling edge
  assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n || !io_rst_n)
    (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $past(sclk_fall));

  assert_out2_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n || !io_rst_n)
    (sdio_oe && $past(sdio_oe) && !$stable(sdio_o)) |-> $past(sclk_fall));
endmodule

bind srp_top srp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rst_n(io_rst_n), .two_wire(two_wire),
  .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdio_o(sdio_o),
  .sdio_oe(sdio_oe), .sclk_fall(sclk_fall), .wr_en(wr_en)
);

// File: tb/tb_srp_top.sv
`timescale 1ns/1ps
module tb_srp_top;
  logic clk, rst_n, io_rst_n, two_wire, cs_n, sclk, sdi, sdio_i;
  logic sdo, sdo_oe, sdio_o, sdio_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [32];
  logic so_oe, sio_oe;

  srp_top dut (
    .clk(clk), .rst_n(rst_n), .io_rst_n(io_rst_n), .two_wire(two_wire),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] step(input logic [4:0] a, input logic up);
    return up ? a + 5'd1 : a - 5'd1;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: falling edge, low half, sample, rising edge, high half
  task automatic clk_bit(input logic b, output logic o);
    sclk = 1'b0; sdi = b; sdio_i = b;
    wait_clk(8);
    o = two_wire ? sdio_o : sdo;
    so_oe = sdo_oe; sio_oe = sdio_oe;
    sclk = 1'b1;
    wait_clk(8);
  endtask

  task automatic do_pause();
    logic o;
    cs_n = 1'b1;
    wait_clk(6);
    chk(!sdo_oe && !sdio_oe, "R9 pause enables", {sdo_oe, sdio_oe}, 0);
    for (int t = 0; t < 3; t++) clk_bit(1'($urandom), o);
    chk(!sdo_oe && !sdio_oe, "R9 pause after clocks", {sdo_oe, sdio_oe}, 0);
    cs_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic run_cycle(input bit rd, input logic [4:0] addr, input int n,
                           input logic [31:0] wd, input int pause_at,
                           input int abort_at, input string req);
    logic up, lsb, o;
    logic [7:0] instr, rb, wb;
    logic [4:0] a;
    int g;
    up = shadow[0][0]; lsb = shadow[0][1];
    instr = {rd, 2'(n - 1), addr};
    cs_n = 1'b0;
    wait_clk(6);
    g = 0;
    for (int i = 0; i < 8; i++) begin
      if (g == pause_at) do_pause();
      if (g == abort_at) begin
        io_rst_n = 1'b0; wait_clk(3); io_rst_n = 1'b1; wait_clk(4);
        cs_n = 1'b1; wait_clk(6);
        return;
      end
      clk_bit(instr[7 - i], o);
      chk(!so_oe && !sio_oe, "R11 instruction enables", {so_oe, sio_oe}, 0);
      g++;
    end
    a = addr;
    for (int k = 0; k < n; k++) begin
      wb = wd[8*k +: 8];
      rb = '0;
      for (int i = 0; i < 8; i++) begin
        if (g == pause_at) do_pause();
        if (g == abort_at) begin
          io_rst_n = 1'b0; wait_clk(3); io_rst_n = 1'b1; wait_clk(4);
          cs_n = 1'b1; wait_clk(6);
          return;
        end
        clk_bit(rd ? 1'($urandom) : (lsb ? wb[i] : wb[7 - i]), o);
        if (rd) begin
          if (lsb) rb[i] = o; else rb[7 - i] = o;
          if (two_wire) chk(sio_oe && !so_oe, "R8 read enables", {so_oe, sio_oe}, 1);
          else          chk(so_oe && !sio_oe, "R7 read enables", {so_oe, sio_oe}, 2);
        end
        g++;
      end
      if (rd) chk(rb == shadow[a], req, rb, shadow[a]);
      else    shadow[a] = wb;
      a = step(a, up);
    end
    wait_clk(4);
    chk(!sdo_oe && !sdio_oe, "R11 after cycle", {sdo_oe, sdio_oe}, 0);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) shadow[i] = 8'h00;
    rst_n = 1'b0; io_rst_n = 1'b1; two_wire = 1'b0;
    cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0; sdio_i = 1'b0;
    so_oe = 1'b0; sio_oe = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state
    chk(!sdo_oe && !sdio_oe, "R1 enables after reset", {sdo_oe, sdio_oe}, 0);
    run_cycle(1, 5'd0, 1, 0, -1, -1, "R1 control byte");
    run_cycle(1, 5'd9, 4, 0, -1, -1, "R1 register bytes");

    // R2 R3 R5: downward stepping, MSB first
    run_cycle(0, 5'd10, 3, 32'h00C3B2A1, -1, -1, "R3");
    run_cycle(1, 5'd8, 1, 0, -1, -1, "R5 down step");
    run_cycle(1, 5'd10, 3, 0, -1, -1, "R2");

    // R5: upward stepping
    run_cycle(0, 5'd0, 1, 32'h01, -1, -1, "R5");
    run_cycle(0, 5'd20, 3, 32'h00665544, -1, -1, "R5");
    run_cycle(1, 5'd21, 2, 0, -1, -1, "R5 up step");

    // R6: LSB first, up then down
    run_cycle(0, 5'd0, 1, 32'h03, -1, -1, "R6");
    run_cycle(0, 5'd12, 2, 32'h0000_3C81, -1, -1, "R6");
    run_cycle(1, 5'd12, 2, 0, -1, -1, "R6 lsb up");
    run_cycle(0, 5'd0, 1, 32'h02, -1, -1, "R6");
    run_cycle(0, 5'd15, 2, 32'h0000_F00D, -1, -1, "R6");
    run_cycle(1, 5'd15, 2, 0, -1, -1, "R6 lsb down");

    // R5: wrap across the top of the address space
    run_cycle(0, 5'd0, 1, 32'h01, -1, -1, "R5");
    run_cycle(0, 5'd31, 1, 32'h5A, -1, -1, "R5");
    run_cycle(1, 5'd31, 2, 0, -1, -1, "R5 wrap");

    // R8: shared-pin mode
    two_wire = 1'b1;
    wait_clk(4);
    run_cycle(0, 5'd4, 2, 32'h0000_9966, -1, -1, "R8");
    run_cycle(1, 5'd4, 2, 0, -1, -1, "R8 shared pin read");
    two_wire = 1'b0;
    wait_clk(4);

    // R9: pause mid-byte in a write and in a read
    run_cycle(0, 5'd6, 2, 32'h0000_E71B, 13, -1, "R9");
    run_cycle(1, 5'd6, 2, 0, 19, -1, "R9 resumed read");
    run_cycle(1, 5'd6, 1, 0, 3, -1, "R9 paused in instruction");

    // R10: abort a write part way through its second byte
    run_cycle(0, 5'd25, 2, 32'h0000_C4B7, -1, 20, "R10");
    shadow[25] = 8'hB7;
    run_cycle(1, 5'd25, 2, 0, -1, -1, "R10 stored bytes");
    run_cycle(1, 5'd0, 1, 0, -1, -1, "R10 control kept");
    run_cycle(0, 5'd3, 1, 32'h77, -1, 4, "R10");
    run_cycle(1, 5'd3, 1, 0, -1, -1, "R10 instruction abort");

    // random mix
    for (int it = 0; it < 50; it++) begin
      two_wire = 1'($urandom);
      wait_clk(4);
      run_cycle(1'($urandom), 5'($urandom), 1 + ($urandom % 4), $urandom,
                -1, -1, "R3 R5 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule